// File: doc/BRIEF.md
# E1 Transmit Slot Timing Generator

This block produces the per-time-slot timing strobes of an E1 transmit path. It runs on the 2.048 MHz transmit bit clock and advances one bit position per clock. Positions are counted as a bit within an 8-bit time slot, a time slot within a 32-slot frame, and a frame within a 16-frame multiframe. A frame is therefore 256 bit times and a multiframe 4096. Bits go out most significant first, so bit index 7 is the least significant bit of a slot. Slot 0 begins on the bit that follows each frame boundary.

Three timing outputs come from the count. A slot clock is high only during the LSB bit time of every slot, giving 256 kHz. A slot gate follows a 32-bit mask for the whole of each slot. The mask is loaded through a write-enable port and only takes over at the next frame start. A sync pin works in one of two directions. As an input, its rising edge realigns the counters to an external frame or multiframe boundary. As an output, it emits a one-bit-wide frame or multiframe pulse. A falling-edge capture of the serial transmit data supplies the sampling point for the data path.

Top module: `e1_tx_slot_timer`

## Requirements
- R1: A synchronous reset sets the position to bit 0, slot 0, frame 0 and clears both the pending and active mask, so `ch_blk`, `ch_clk` and `ser_q` read 0 while reset is applied and after it.
- R2: The position advances by one bit per clock through 8 bits per slot, 32 slots per frame and 16 frames per multiframe. `ch_clk` is 1 exactly when the bit index is 7, which is one clock in eight and only one clock wide.
- R3: During all 8 bits of slot n, `ch_blk` equals bit n of the active mask (mask bit 0 is slot 0, mask bit 31 is slot 31; 1 drives `ch_blk` high).
- R4: A value written with `mask_wr_en` = 1 becomes active on the first bit of the next frame. Until then the previous mask remains in force. A write sampled on the last bit of a frame waits for the following frame.
- R5: With `sync_dir_out` = 1 and `sync_multi` = 0, `sync_o` is 1 for one clock at bit 0 of slot 0 of every frame.
- R6: With `sync_dir_out` = 1 and `sync_multi` = 1, `sync_o` is 1 for one clock at bit 0 of slot 0 of frame 0 only.
- R7: With `sync_dir_out` = 0 and `sync_multi` = 0, a rising edge on `sync_i` sampled at a clock edge makes the next clock bit 0 of slot 0 and advances the frame count by one.
- R8: With `sync_dir_out` = 0 and `sync_multi` = 1, a rising edge on `sync_i` makes the next clock bit 0 of slot 0 of frame 0.
- R9: A sync edge that arrives when the count is already on the last bit of the frame (frame select) or of the multiframe (multiframe select) changes nothing. A level held high on `sync_i` acts only at its rising edge.
- R10: `sync_oe` equals `sync_dir_out`. While `sync_dir_out` = 1, `sync_i` has no effect on the count. While `sync_dir_out` = 0, `sync_o` stays 0.
- R11: `ser_q` holds the value of `tx_ser` captured at the most recent falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, 2.048 MHz |
| rst | input | 1 | Synchronous active-high reset |
| tx_ser | input | 1 | Serial NRZ transmit data |
| sync_i | input | 1 | Sync pin input value |
| sync_dir_out | input | 1 | 1: sync pin drives out; 0: sync pin is an input |
| sync_multi | input | 1 | 1: multiframe boundary; 0: frame boundary |
| mask_wr_en | input | 1 | Load `mask_wr_data` into the pending mask |
| mask_wr_data | input | 32 | New slot gate mask, bit n for slot n |
| ch_clk | output | 1 | High during the LSB bit time of each slot |
| ch_blk | output | 1 | Gate level of the current slot |
| sync_o | output | 1 | Frame or multiframe pulse when driving out |
| sync_oe | output | 1 | Output enable for the sync pin |
| ser_q | output | 1 | `tx_ser` captured on the falling clock edge |

## Verification
The bench builds the block with its default parameters: 8 bits per slot, 32 slots and 16 frames. With these values a whole 4096-bit multiframe takes only a few thousand clocks, so the bench can watch the multiframe pulse wrap after every realignment. That makes a shift of the frame count by one visible. An internal position model checks every output on every clock. Tabled mask and slot pairs reach slot 0 and slot 31. Directed cases place sync edges on the agreeing last bit of a frame and of a multiframe, hold the pin high, and send edges while the pin drives out.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;

    localparam int unsigned E1_BITS_PER_SLOT = 8;
    localparam int unsigned E1_SLOTS         = 32;
    localparam int unsigned E1_FRAMES_PER_MF = 16;

    typedef enum logic {
        SYNC_FRAME = 1'b0,
        SYNC_MULTI = 1'b1
    } sync_mode_e;

    typedef struct packed {
        logic       drive_out;
        sync_mode_e mode;
    } sync_cfg_t;

    typedef struct packed {
        logic frame_first;
        logic mf_first;
        logic slot_last_bit;
        logic frame_ends;
    } slot_marks_t;

    function automatic int unsigned wrap_next(int unsigned v, int unsigned lim);
        return (v >= lim - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/e1_tx_slot_counter.sv
module e1_tx_slot_counter
    import e1_tx_pkg::*;
#(
    parameter int unsigned BITS   = E1_BITS_PER_SLOT,
    parameter int unsigned SLOTS  = E1_SLOTS,
    parameter int unsigned FRAMES = E1_FRAMES_PER_MF,
    localparam int unsigned BW = (BITS   > 1) ? $clog2(BITS)   : 1,
    localparam int unsigned SW = (SLOTS  > 1) ? $clog2(SLOTS)  : 1,
    localparam int unsigned FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_mf,
    output logic [SW-1:0] slot_idx,
    output slot_marks_t   marks
);

    logic [BW-1:0] bit_idx;
    logic [FW-1:0] frm_idx;
    logic          last_bit;
    logic          last_slot;

    assign last_bit  = (bit_idx  == BW'(BITS - 1));
    assign last_slot = (slot_idx == SW'(SLOTS - 1));

    assign marks.slot_last_bit = last_bit;
    assign marks.frame_first   = (bit_idx == '0) && (slot_idx == '0);
    assign marks.mf_first      = marks.frame_first && (frm_idx == '0);
    assign marks.frame_ends    = load || (last_bit && last_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx  <= '0;
            slot_idx <= '0;
            frm_idx  <= '0;
        end else if (load) begin
            bit_idx  <= '0;
            slot_idx <= '0;
            frm_idx  <= load_mf ? '0 : FW'(wrap_next(32'(frm_idx), FRAMES));
        end else begin
            bit_idx <= BW'(wrap_next(32'(bit_idx), BITS));
            if (last_bit) begin
                slot_idx <= SW'(wrap_next(32'(slot_idx), SLOTS));
                if (last_slot)
                    frm_idx <= FW'(wrap_next(32'(frm_idx), FRAMES));
            end
        end
    end

    // R7
    load_aligns_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_idx == '0 && slot_idx == '0));

    // R8
    load_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_mf) |=> (frm_idx == '0));

    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !(last_bit && last_slot)) |=> $stable(frm_idx));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !last_bit) |=> $stable(slot_idx));

endmodule

// File: rtl/e1_tx_sync_port.sv
module e1_tx_sync_port
    import e1_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    input  sync_cfg_t cfg,
    input  logic      frame_first,
    input  logic      mf_first,
    output logic      load,
    output logic      load_mf,
    output logic      sync_o,
    output logic      sync_oe
);

    logic sync_prev;
    logic sync_rise;

    always_ff @(posedge clk) begin
        if (rst) sync_prev <= 1'b0;
        else     sync_prev <= sync_i;
    end

    assign sync_rise = sync_i && !sync_prev;
    assign load      = sync_rise && !cfg.drive_out;
    assign load_mf   = (cfg.mode == SYNC_MULTI);
    assign sync_oe   = cfg.drive_out;
    assign sync_o    = cfg.drive_out && frame_first &&
                       ((cfg.mode == SYNC_FRAME) || mf_first);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);

    // R9
    level_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sync_i) && sync_i) |-> !load);

endmodule

// File: rtl/e1_tx_slot_mask.sv
module e1_tx_slot_mask #(
    parameter int unsigned SLOTS = 32,
    localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SLOTS-1:0] wr_data,
    input  logic             frame_ends,
    input  logic             slot_last_bit,
    input  logic [SW-1:0]    slot_idx,
    output logic             blk
);

    logic [SLOTS-1:0] pend_mask;
    logic [SLOTS-1:0] act_mask;
    logic [SLOTS-1:0] slot_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_mask <= '0;
            act_mask  <= '0;
        end else begin
            if (frame_ends) act_mask  <= pend_mask;
            if (wr_en)      pend_mask <= wr_data;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_sel
        assign slot_sel[s] = act_mask[s] && (slot_idx == SW'(s));
    end

    assign blk = |slot_sel;

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_ends |=> $stable(act_mask));

    // R3
    gate_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_last_bit && !frame_ends) |=> $stable(blk));

endmodule

// File: rtl/e1_tx_slot_timer.sv
module e1_tx_slot_timer
    import e1_tx_pkg::*;
#(
    parameter int unsigned BITS   = E1_BITS_PER_SLOT,
    parameter int unsigned SLOTS  = E1_SLOTS,
    parameter int unsigned FRAMES = E1_FRAMES_PER_MF,
    localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_ser,
    input  logic             sync_i,
    input  logic             sync_dir_out,
    input  logic             sync_multi,
    input  logic             mask_wr_en,
    input  logic [SLOTS-1:0] mask_wr_data,
    output logic             ch_clk,
    output logic             ch_blk,
    output logic             sync_o,
    output logic             sync_oe,
    output logic             ser_q
);

    sync_cfg_t   cfg;
    slot_marks_t marks;
    logic [SW-1:0] slot_idx;
    logic        load;
    logic        load_mf;

    assign cfg.drive_out = sync_dir_out;
    assign cfg.mode      = sync_mode_e'(sync_multi);

    e1_tx_slot_counter #(.BITS(BITS), .SLOTS(SLOTS), .FRAMES(FRAMES)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_mf  (load_mf),
        .slot_idx (slot_idx),
        .marks    (marks)
    );

    e1_tx_sync_port u_sync (
        .clk         (clk),
        .rst         (rst),
        .sync_i      (sync_i),
        .cfg         (cfg),
        .frame_first (marks.frame_first),
        .mf_first    (marks.mf_first),
        .load        (load),
        .load_mf     (load_mf),
        .sync_o      (sync_o),
        .sync_oe     (sync_oe)
    );

    e1_tx_slot_mask #(.SLOTS(SLOTS)) u_mask (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (mask_wr_en),
        .wr_data       (mask_wr_data),
        .frame_ends    (marks.frame_ends),
        .slot_last_bit (marks.slot_last_bit),
        .slot_idx      (slot_idx),
        .blk           (ch_blk)
    );

    assign ch_clk = marks.slot_last_bit;

    always_ff @(negedge clk) begin
        if (rst) ser_q <= 1'b0;
        else     ser_q <= tx_ser;
    end

    // R2
    ch_clk_width_chk: assert property (@(posedge clk) disable iff (rst)
        ch_clk |=> !ch_clk);

    // R10
    input_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        sync_oe |-> !load);

endmodule

// File: tb/e1_tx_slot_timer_tb.sv
`timescale 1ns/1ps
module e1_tx_slot_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_ser = 1'b0;
    logic        sync_i = 1'b0;
    logic        sync_dir_out = 1'b1;
    logic        sync_multi = 1'b1;
    logic        mask_wr_en = 1'b0;
    logic [31:0] mask_wr_data = '0;
    logic        ch_clk, ch_blk, sync_o, sync_oe, ser_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          pos = 0;
    logic [31:0] pend = '0;
    logic [31:0] act  = '0;
    logic        prev_s = 1'b0;
    logic        ser_exp = 1'b0;
    logic [7:0]  lf = 8'h5B;

    // mask, slot, expected gate
    localparam logic [37:0] VEC [8] = '{
        {32'h0000_0001, 5'd0,  1'b1},
        {32'h8000_0000, 5'd31, 1'b1},
        {32'h8000_0000, 5'd30, 1'b0},
        {32'hAAAA_AAAA, 5'd5,  1'b1},
        {32'hAAAA_AAAA, 5'd4,  1'b0},
        {32'h0001_0000, 5'd16, 1'b1},
        {32'hFFFF_FFFF, 5'd12, 1'b1},
        {32'h0000_0000, 5'd12, 1'b0}
    };

    e1_tx_slot_timer u_dut (
        .clk(clk), .rst(rst), .tx_ser(tx_ser), .sync_i(sync_i),
        .sync_dir_out(sync_dir_out), .sync_multi(sync_multi),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .ch_clk(ch_clk), .ch_blk(ch_blk), .sync_o(sync_o),
        .sync_oe(sync_oe), .ser_q(ser_q)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, string name, logic [31:0] a, logic [31:0] e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h (pos %0d)", tag, name, a, e, pos);
        end
    endtask

    task automatic tick();
        int  npos;
        logic rise;
        @(posedge clk);
        if (rst) begin
            pos = 0; pend = '0; act = '0; prev_s = 1'b0;
        end else begin
            rise   = sync_i && !prev_s && !sync_dir_out;
            prev_s = sync_i;
            if (rise) npos = sync_multi ? 0 : (((pos / 256) + 1) % 16) * 256;
            else      npos = (pos + 1) % 4096;
            if (npos % 256 == 0) act = pend;
            if (mask_wr_en) pend = mask_wr_data;
            pos = npos;
        end
        ser_exp = rst ? 1'b0 : tx_ser;
        #6;
    endtask

    task automatic check_now(string tc, string tb_, string ts);
        logic es;
        es = sync_dir_out && (sync_multi ? (pos == 0) : (pos % 256 == 0));
        chk(tc, "ch_clk", 32'(ch_clk), 32'(pos % 8 == 7));
        chk(tb_, "ch_blk", 32'(ch_blk), 32'(act[(pos / 8) % 32]));
        chk(ts, "sync_o", 32'(sync_o), 32'(es));
        chk("R10", "sync_oe", 32'(sync_oe), 32'(sync_dir_out));
        chk("R11", "ser_q", 32'(ser_q), 32'(ser_exp));
    endtask

    task automatic scan(int n, string tc, string tb_, string ts);
        for (int k = 0; k < n; k++) begin
            tick();
            check_now(tc, tb_, ts);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            tx_ser = lf[0];
        end
    endtask

    task automatic pulse(string tag);
        sync_i = 1'b1;
        scan(1, tag, "R3", tag);
        sync_i = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int k = 0; k < 3; k++) tick();
        chk("R1", "ch_clk", 32'(ch_clk), 32'd0);
        chk("R1", "ch_blk", 32'(ch_blk), 32'd0);
        chk("R1", "ser_q", 32'(ser_q), 32'd0);
        chk("R1", "sync_o", 32'(sync_o), 32'd1);
        rst = 1'b0;
        sync_multi = 1'b0;

        // R2 R5: free running frame pulses
        scan(600, "R2", "R3", "R5");

        // R3 R4: tabled masks
        for (int v = 0; v < 8; v++) begin
            while (pos % 256 == 255) scan(1, "R2", "R4", "R5");
            mask_wr_en   = 1'b1;
            mask_wr_data = VEC[v][37:6];
            scan(1, "R2", "R4", "R5");
            mask_wr_en   = 1'b0;
            while (pos % 256 != 0) scan(1, "R2", "R4", "R5");
            while (((pos / 8) % 32) != int'(VEC[v][5:1]) || (pos % 8) != 0)
                scan(1, "R2", "R3", "R5");
            for (int b = 0; b < 8; b++) begin
                chk("R3", "ch_blk table", 32'(ch_blk), 32'(VEC[v][0]));
                scan(1, "R2", "R3", "R5");
            end
            scan(1, "R2", "R3", "R5");
        end

        // R4: write on the last bit of a frame waits a full frame
        while (pos % 256 != 255) scan(1, "R2", "R4", "R5");
        mask_wr_en = 1'b1; mask_wr_data = 32'h0000_0001;
        scan(1, "R2", "R4", "R5");
        mask_wr_en = 1'b0;
        chk("R4", "ch_blk slot0 old", 32'(ch_blk), 32'd0);
        scan(300, "R2", "R4", "R5");

        // R6: multiframe output
        sync_multi = 1'b1;
        scan(4200, "R2", "R3", "R6");

        // R7: frame realign by input
        sync_dir_out = 1'b0; sync_multi = 1'b0;
        scan(53, "R7", "R3", "R10");
        pulse("R7");
        scan(300, "R7", "R7", "R10");
        sync_dir_out = 1'b1; sync_multi = 1'b1;
        scan(4200, "R7", "R3", "R7");

        // R8: multiframe realign by input
        sync_dir_out = 1'b0;
        scan(1300, "R8", "R3", "R10");
        pulse("R8");
        scan(100, "R8", "R8", "R10");
        sync_dir_out = 1'b1;
        scan(4200, "R8", "R3", "R8");

        // R9: agreeing edges and a held level
        sync_dir_out = 1'b0; sync_multi = 1'b0;
        while (pos % 256 != 255) scan(1, "R9", "R3", "R10");
        pulse("R9");
        sync_multi = 1'b1;
        while (pos != 4095) scan(1, "R9", "R3", "R10");
        pulse("R9");
        scan(37, "R9", "R3", "R10");
        sync_i = 1'b1;
        scan(600, "R9", "R3", "R10");
        sync_i = 1'b0;
        sync_dir_out = 1'b1;
        scan(4200, "R9", "R3", "R9");

        // R10: edges ignored while driving out
        scan(701, "R10", "R3", "R6");
        pulse("R10");
        scan(4200, "R10", "R3", "R10");

        // R1: reset clears an active mask
        sync_multi = 1'b0;
        mask_wr_en = 1'b1; mask_wr_data = 32'hFFFF_FFFF;
        scan(1, "R2", "R4", "R5");
        mask_wr_en = 1'b0;
        scan(300, "R2", "R4", "R5");
        rst = 1'b1;
        tick(); tick();
        chk("R1", "ch_blk after mask", 32'(ch_blk), 32'd0);
        chk("R1", "ser_q", 32'(ser_q), 32'd0);
        rst = 1'b0;
        scan(300, "R1", "R1", "R1");

        done = 1;
        summary();
        $finish;
    end

endmodule